// File: doc/BRIEF.md
# Dual Wiper Position Register Bank

This block holds the working (volatile) wiper positions of two independent tap selectors. Channel A has 100 taps (0 to 99) and channel B has 256 taps (0 to 255). Each position register drives a one-hot select bus. Bit 0 of a bus enables the switch at the low end of its resistor chain, and the top bit enables the switch at the high end. The resistor chains and the nonvolatile store sit outside the block. The store presents its saved positions on `nv_a` and `nv_b`.

After reset, both registers hold tap 0. A recall controller waits a fixed number of cycles and then copies the nonvolatile positions into the registers. A recall request can repeat that copy at any later time. Once the recall has finished, each register can be written through its own port, and its current value can be read back. Every change of position is applied break-before-make. The select bus goes fully off for exactly one cycle before the new tap switch turns on.

The recall controller has three states:
- `RCL_BOOT` counts `RECALL_DLY` cycles after reset and then moves to `RCL_LOAD`.
- `RCL_LOAD` copies the nonvolatile inputs for one cycle and always moves to `RCL_READY`.
- `RCL_READY` accepts writes, and moves to `RCL_LOAD` when `recall_req` is high.

Each tap decoder has two states:
- `DEC_HOLD` drives the one-hot tap. It moves to `DEC_BREAK` when the register value differs from the tap being driven.
- `DEC_BREAK` drives all switches off for one cycle and always returns to `DEC_HOLD`.

Top module: `dual_wiper_bank`

## Requirements
- R1: While `rst_n` is low, `rd_a` and `rd_b` read 0, and `sel_a` and `sel_b` each have only bit 0 set.
- R2: After `rst_n` rises, writes are ignored for the first `RECALL_DLY` (default 4) rising edges. At the next edge, `rd_a` takes `nv_a` and `rd_b` takes `nv_b`.
- R3: Channel A never holds a value above 99. A write value or nonvolatile value above 99 is stored as 99.
- R4: Channel B stores any value from 0 to 255 unchanged.
- R5: In the ready state, a write with `wr_en_a` or `wr_en_b` high updates that channel at the next rising edge. `rd_a` and `rd_b` always show the volatile register, not `nv_a` or `nv_b`.
- R6: A `recall_req` sampled high in the ready state reloads both registers from the nonvolatile inputs one edge later. Writes in that load cycle are ignored.
- R7: Each select bus has at most one bit set. Once a position has been stable, bit N is set for position N.
- R8: When a register changes at edge E, its select bus is all-off after edge E+1 and shows the new tap after edge E+2. No select bit rises unless the bus was all-off in the previous cycle, and an all-off bus lasts only one cycle.
- R9: Writing the value a register already holds causes no all-off gap, and the select bus does not change.
- R10: A write to one channel leaves the other channel's register and select bus unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| recall_req | input | 1 | Request to reload both registers from the nonvolatile inputs |
| nv_a | input | DW | Saved nonvolatile position for channel A |
| nv_b | input | DW | Saved nonvolatile position for channel B |
| wr_en_a | input | 1 | Write strobe for channel A |
| wr_data_a | input | DW | Write value for channel A (stored as 99 if above 99) |
| wr_en_b | input | 1 | Write strobe for channel B |
| wr_data_b | input | DW | Write value for channel B |
| rd_a | output | DW | Current volatile position of channel A |
| rd_b | output | DW | Current volatile position of channel B |
| sel_a | output | TAPS_A | One-hot tap select for channel A, bit 0 at the low end |
| sel_b | output | TAPS_B | One-hot tap select for channel B, bit 0 at the low end |

## Verification
The assertions assume that reset stays low for at least three clock edges. This lets the three-cycle history used by the tap-match property start from the reset values. The stimulus holds reset for four edges.

The assertions also assume that every input changes only away from the rising edge. The bench drives all inputs just after the falling edge and samples outputs there too. Between positions, the vector walk waits three edges, long enough for each break-before-make gap to finish before the next write.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    // Recall sequencing states
    typedef enum logic [1:0] {
        RCL_BOOT  = 2'd0,
        RCL_LOAD  = 2'd1,
        RCL_READY = 2'd2
    } rcl_state_e;

    // Break-before-make tap decoder states
    typedef enum logic {
        DEC_HOLD  = 1'b0,
        DEC_BREAK = 1'b1
    } dec_state_e;

endpackage

// File: rtl/wiper_recall_ctl.sv
module wiper_recall_ctl
    import wiper_pkg::*;
#(
    parameter int RECALL_DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic recall_req,
    output logic load_nv,
    output logic wr_allow
);
    localparam int CW = (RECALL_DLY > 1) ? $clog2(RECALL_DLY) : 1;
    localparam logic [CW-1:0] LAST = CW'(RECALL_DLY - 1);

    rcl_state_e      state, nxt_state;
    logic [CW-1:0]   cnt, nxt_cnt;

    // next-state logic
    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        unique case (state)
            RCL_BOOT: begin
                if (cnt == LAST) begin
                    nxt_state = RCL_LOAD;
                    nxt_cnt   = '0;
                end else begin
                    nxt_cnt = cnt + 1'b1;
                end
            end
            RCL_LOAD: begin
                nxt_state = RCL_READY;
            end
            RCL_READY: begin
                if (recall_req) begin
                    nxt_state = RCL_LOAD;
                end
            end
            default: begin
                nxt_state = RCL_BOOT;
                nxt_cnt   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RCL_BOOT;
            cnt   <= '0;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
        end
    end

    // outputs
    always_comb begin
        load_nv  = 1'b0;
        wr_allow = 1'b0;
        unique case (state)
            RCL_BOOT:  ;
            RCL_LOAD:  load_nv  = 1'b1;
            RCL_READY: wr_allow = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/tap_decoder.sv
module tap_decoder
    import wiper_pkg::*;
#(
    parameter int TAPS = 100,
    parameter int PW   = $clog2(TAPS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PW-1:0]   pos,
    output logic [TAPS-1:0] sel
);
    localparam logic [TAPS-1:0] LOW_END = TAPS'(1);

    dec_state_e      state, nxt_state;
    logic [PW-1:0]   cur, nxt_cur;
    logic [TAPS-1:0] hot;

    // one comparator per tap switch
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign hot[i] = (nxt_cur == PW'(i));
    end

    // next-state logic
    always_comb begin
        nxt_state = state;
        nxt_cur   = cur;
        unique case (state)
            DEC_HOLD: begin
                if (pos != cur) begin
                    nxt_state = DEC_BREAK;
                    nxt_cur   = pos;
                end
            end
            DEC_BREAK: begin
                nxt_state = DEC_HOLD;
            end
            default: begin
                nxt_state = DEC_HOLD;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= DEC_HOLD;
            cur   <= '0;
        end else begin
            state <= nxt_state;
            cur   <= nxt_cur;
        end
    end

    // registered switch outputs: all off while breaking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel <= LOW_END;
        end else begin
            unique case (nxt_state)
                DEC_BREAK: sel <= '0;
                DEC_HOLD:  sel <= hot;
                default:   sel <= '0;
            endcase
        end
    end

endmodule

// File: rtl/wiper_channel.sv
module wiper_channel #(
    parameter int TAPS = 100,
    parameter int DW   = 8,
    parameter int PW   = $clog2(TAPS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_nv,
    input  logic            wr_allow,
    input  logic [DW-1:0]   nv,
    input  logic            wr_en,
    input  logic [DW-1:0]   wr_data,
    output logic [DW-1:0]   rd,
    output logic [TAPS-1:0] sel
);
    localparam logic [DW-1:0] TOP_IN  = DW'(TAPS - 1);
    localparam logic [PW-1:0] TOP_POS = PW'(TAPS - 1);

    logic [PW-1:0] wiper;

    function automatic logic [PW-1:0] fit(input logic [DW-1:0] v);
        fit = (v > TOP_IN) ? TOP_POS : v[PW-1:0];
    endfunction

    // volatile position register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wiper <= '0;
        end else if (load_nv) begin
            wiper <= fit(nv);
        end else if (wr_allow && wr_en) begin
            wiper <= fit(wr_data);
        end
    end

    assign rd = DW'(wiper);

    tap_decoder #(
        .TAPS (TAPS),
        .PW   (PW)
    ) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .pos   (wiper),
        .sel   (sel)
    );

endmodule

// File: rtl/dual_wiper_bank.sv
module dual_wiper_bank #(
    parameter int TAPS_A     = 100,
    parameter int TAPS_B     = 256,
    parameter int DW         = 8,
    parameter int RECALL_DLY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              recall_req,
    input  logic [DW-1:0]     nv_a,
    input  logic [DW-1:0]     nv_b,
    input  logic              wr_en_a,
    input  logic [DW-1:0]     wr_data_a,
    input  logic              wr_en_b,
    input  logic [DW-1:0]     wr_data_b,
    output logic [DW-1:0]     rd_a,
    output logic [DW-1:0]     rd_b,
    output logic [TAPS_A-1:0] sel_a,
    output logic [TAPS_B-1:0] sel_b
);
    logic load_nv;
    logic wr_allow;

    wiper_recall_ctl #(
        .RECALL_DLY (RECALL_DLY)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .recall_req (recall_req),
        .load_nv    (load_nv),
        .wr_allow   (wr_allow)
    );

    wiper_channel #(
        .TAPS (TAPS_A),
        .DW   (DW)
    ) u_ch_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_nv  (load_nv),
        .wr_allow (wr_allow),
        .nv       (nv_a),
        .wr_en    (wr_en_a),
        .wr_data  (wr_data_a),
        .rd       (rd_a),
        .sel      (sel_a)
    );

    wiper_channel #(
        .TAPS (TAPS_B),
        .DW   (DW)
    ) u_ch_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_nv  (load_nv),
        .wr_allow (wr_allow),
        .nv       (nv_b),
        .wr_en    (wr_en_b),
        .wr_data  (wr_data_b),
        .rd       (rd_b),
        .sel      (sel_b)
    );

endmodule

// File: rtl/dual_wiper_bank_chk.sv
module dual_wiper_bank_chk #(
    parameter int TAPS_A = 100,
    parameter int TAPS_B = 256,
    parameter int DW     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_nv,
    input logic              wr_allow,
    input logic [DW-1:0]     nv_a,
    input logic [DW-1:0]     nv_b,
    input logic              wr_en_a,
    input logic [DW-1:0]     wr_data_a,
    input logic              wr_en_b,
    input logic [DW-1:0]     wr_data_b,
    input logic [DW-1:0]     rd_a,
    input logic [DW-1:0]     rd_b,
    input logic [TAPS_A-1:0] sel_a,
    input logic [TAPS_B-1:0] sel_b
);
    localparam logic [DW-1:0]     MAX_A = DW'(TAPS_A - 1);
    localparam logic [TAPS_A-1:0] ONE_A = TAPS_A'(1);
    localparam logic [TAPS_B-1:0] ONE_B = TAPS_B'(1);

    p_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a <= MAX_A);

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_nv |=> (rd_a == (($past(nv_a) > MAX_A) ? MAX_A : $past(nv_a)))
                    && (rd_b == $past(nv_b)));

    p_write_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_allow && wr_en_a) |=>
            rd_a == (($past(wr_data_a) > MAX_A) ? MAX_A : $past(wr_data_a)));

    p_write_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_allow && wr_en_b) |=> rd_b == $past(wr_data_b));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_allow && !load_nv) |=> ($stable(rd_a) && $stable(rd_b)));

    p_idle_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_nv && !wr_en_a) |=> $stable(rd_a));

    p_onehot_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_a));

    p_onehot_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_b));

    p_no_overlap_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sel_a & ~$past(sel_a))) |-> ($past(sel_a) == '0));

    p_no_overlap_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sel_b & ~$past(sel_b))) |-> ($past(sel_b) == '0));

    p_gap_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a == '0) |=> (sel_a != '0));

    p_gap_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b == '0) |=> (sel_b != '0));

    p_match_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a == $past(rd_a, 1) && rd_a == $past(rd_a, 2) && rd_a == $past(rd_a, 3))
            |-> (sel_a == (ONE_A << rd_a)));

    p_match_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b == $past(rd_b, 1) && rd_b == $past(rd_b, 2) && rd_b == $past(rd_b, 3))
            |-> (sel_b == (ONE_B << rd_b)));

endmodule

bind dual_wiper_bank dual_wiper_bank_chk #(
    .TAPS_A (TAPS_A),
    .TAPS_B (TAPS_B),
    .DW     (DW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_nv   (load_nv),
    .wr_allow  (wr_allow),
    .nv_a      (nv_a),
    .nv_b      (nv_b),
    .wr_en_a   (wr_en_a),
    .wr_data_a (wr_data_a),
    .wr_en_b   (wr_en_b),
    .wr_data_b (wr_data_b),
    .rd_a      (rd_a),
    .rd_b      (rd_b),
    .sel_a     (sel_a),
    .sel_b     (sel_b)
);

// File: tb/dual_wiper_bank_tb.sv
module dual_wiper_bank_tb;
    localparam int TAPS_A = 100;
    localparam int TAPS_B = 256;
    localparam int DW     = 8;

    typedef struct packed {
        logic       wa;
        logic [7:0] da;
        logic       wb;
        logic [7:0] db;
        logic [7:0] ea;
        logic [7:0] eb;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'd10,  1'b1, 8'd20,  8'd10, 8'd20},
        '{1'b1, 8'd99,  1'b0, 8'd0,   8'd99, 8'd20},
        '{1'b1, 8'd100, 1'b1, 8'd255, 8'd99, 8'd255},
        '{1'b1, 8'd255, 1'b1, 8'd0,   8'd99, 8'd0},
        '{1'b0, 8'd50,  1'b1, 8'd128, 8'd99, 8'd128},
        '{1'b1, 8'd0,   1'b1, 8'd128, 8'd0,  8'd128},
        '{1'b1, 8'd98,  1'b0, 8'd7,   8'd98, 8'd128},
        '{1'b1, 8'd127, 1'b1, 8'd1,   8'd99, 8'd1},
        '{1'b1, 8'd1,   1'b1, 8'd254, 8'd1,  8'd254},
        '{1'b1, 8'd64,  1'b1, 8'd255, 8'd64, 8'd255}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              recall_req = 1'b0;
    logic [DW-1:0]     nv_a = '0;
    logic [DW-1:0]     nv_b = '0;
    logic              wr_en_a = 1'b0;
    logic [DW-1:0]     wr_data_a = '0;
    logic              wr_en_b = 1'b0;
    logic [DW-1:0]     wr_data_b = '0;
    logic [DW-1:0]     rd_a;
    logic [DW-1:0]     rd_b;
    logic [TAPS_A-1:0] sel_a;
    logic [TAPS_B-1:0] sel_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    dual_wiper_bank #(
        .TAPS_A (TAPS_A), .TAPS_B (TAPS_B), .DW (DW), .RECALL_DLY (4)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .recall_req (recall_req),
        .nv_a (nv_a), .nv_b (nv_b),
        .wr_en_a (wr_en_a), .wr_data_a (wr_data_a),
        .wr_en_b (wr_en_b), .wr_data_b (wr_data_b),
        .rd_a (rd_a), .rd_b (rd_b), .sel_a (sel_a), .sel_b (sel_b)
    );

    function automatic logic [TAPS_A-1:0] hot_a(input int p);
        logic [TAPS_A-1:0] v = '0;
        v[p] = 1'b1;
        return v;
    endfunction

    function automatic logic [TAPS_B-1:0] hot_b(input int p);
        logic [TAPS_B-1:0] v = '0;
        v[p] = 1'b1;
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int pa, pb;

        // R1: reset state, with recall data and a write already presented
        nv_a = 8'd150;
        nv_b = 8'd200;
        wr_en_a = 1'b1;
        wr_data_a = 8'd5;
        repeat (4) step();
        chk(rd_a == 0, "R1 rd_a in reset", rd_a, 0);
        chk(rd_b == 0, "R1 rd_b in reset", rd_b, 0);
        chk(sel_a == hot_a(0), "R1 sel_a in reset", sel_a, hot_a(0));
        chk(sel_b == hot_b(0), "R1 sel_b in reset", sel_b, hot_b(0));

        // R2: writes ignored during the boot wait, recall lands on edge 5
        rst_n = 1'b1;
        repeat (4) step();
        chk(rd_a == 0, "R2 write ignored while booting", rd_a, 0);
        step();
        wr_en_a = 1'b0;
        chk(rd_a == 99, "R2/R3 recall clamps nv_a", rd_a, 99);
        chk(rd_b == 200, "R2 recall nv_b", rd_b, 200);
        step();
        chk(sel_a == '0, "R8 sel_a gap after recall", sel_a, 0);
        chk(sel_b == '0, "R8 sel_b gap after recall", sel_b, 0);
        step();
        chk(sel_a == hot_a(99), "R7 sel_a top tap", sel_a, hot_a(99));
        chk(sel_b == hot_b(200), "R7 sel_b tap 200", sel_b, hot_b(200));
        pa = 99;
        pb = 200;

        // vector walk: R3 R4 R5 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            wr_en_a = VEC[i].wa;
            wr_data_a = VEC[i].da;
            wr_en_b = VEC[i].wb;
            wr_data_b = VEC[i].db;
            step();
            wr_en_a = 1'b0;
            wr_en_b = 1'b0;
            chk(rd_a == VEC[i].ea, "R3/R5 rd_a after write", rd_a, VEC[i].ea);
            chk(rd_b == VEC[i].eb, VEC[i].wb ? "R4/R5 rd_b after write" : "R10 rd_b untouched",
                rd_b, VEC[i].eb);
            step();
            if (int'(VEC[i].ea) == pa)
                chk(sel_a == hot_a(pa), "R9 sel_a no gap on same value", sel_a, hot_a(pa));
            else
                chk(sel_a == '0, "R8 sel_a break cycle", sel_a, 0);
            if (int'(VEC[i].eb) == pb)
                chk(sel_b == hot_b(pb), "R9/R10 sel_b unchanged", sel_b, hot_b(pb));
            else
                chk(sel_b == '0, "R8 sel_b break cycle", sel_b, 0);
            step();
            chk(sel_a == hot_a(VEC[i].ea), "R7 sel_a new tap", sel_a, hot_a(VEC[i].ea));
            chk(sel_b == hot_b(VEC[i].eb), "R7 sel_b new tap", sel_b, hot_b(VEC[i].eb));
            pa = int'(VEC[i].ea);
            pb = int'(VEC[i].eb);
        end

        // R6: recall request, write in the load cycle ignored
        nv_a = 8'd42;
        nv_b = 8'd7;
        recall_req = 1'b1;
        step();
        recall_req = 1'b0;
        chk(rd_a == 64, "R6 rd_a before reload", rd_a, 64);
        wr_en_a = 1'b1;
        wr_data_a = 8'd77;
        wr_en_b = 1'b1;
        wr_data_b = 8'd9;
        step();
        wr_en_a = 1'b0;
        wr_en_b = 1'b0;
        chk(rd_a == 42, "R6 rd_a reloaded", rd_a, 42);
        chk(rd_b == 7, "R6 rd_b reloaded", rd_b, 7);
        step();
        step();
        chk(sel_a == hot_a(42), "R6/R7 sel_a after reload", sel_a, hot_a(42));
        chk(sel_b == hot_b(7), "R6/R7 sel_b after reload", sel_b, hot_b(7));

        // R3 + R6: recall of an out-of-range value clamps
        nv_a = 8'd200;
        recall_req = 1'b1;
        step();
        recall_req = 1'b0;
        step();
        chk(rd_a == 99, "R3/R6 recall clamp", rd_a, 99);
        chk(rd_b == 7, "R6 rd_b same nv", rd_b, 7);

        // R1: reset mid-run
        rst_n = 1'b0;
        step();
        chk(rd_a == 0 && sel_a == hot_a(0), "R1 reset mid-run", rd_a, 0);
        rst_n = 1'b1;
        step();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule